// File: doc/BRIEF.md
# Jittered Fixed-Frequency PWM Oscillator

This block is the timing source of a fixed-frequency current-mode PWM controller. It counts system clocks to mark the start of each switching period. For each period it asserts a maximum-duty window that stays inside three quarters of that period. To spread conducted emissions, the length of every switching period is moved slowly up and down along a triangular profile. The deviation is about ±4 % of the nominal period, and one full sweep takes close to 4 ms.

The same block also holds a digital soft-start ramp. A start pulse sets an 8-bit duty-limit code to zero. The code then climbs in evenly spaced ticks and reaches full scale when the configured soft-start time (20 ms or 10 ms) has passed. It stays at full scale after that, and normal loop control takes over from there. A run enable gates the whole block: while it is low, no cycle-start pulses appear and both the modulation and the ramp are held at zero. The comparator that ends each on-time and the gate driver are not part of this block.

Derived values: nominal period `NOM = SYS_CLK_KHZ / SW_KHZ` clocks, deviation `DEV = NOM*DEV_PCT/100` clocks, `STEP = (SW_KHZ*MOD_US/1000/4) / DEV` switching periods per modulation level, and ramp tick `TICK = SYS_CLK_KHZ*SOFT_MS / 255` clocks.

Top module: `jitter_pwm_osc`

## Requirements
- R1: While reset is asserted, and afterwards while `run_i` stays low, `cyc_start_o`, `duty_win_o` and `ss_code_o` are all zero.
- R2: `cyc_start_o` goes high in the first clock after the edge at which `run_i` is sampled high. It is one clock wide and marks the first clock of every switching period.
- R3: Switching period n (counted from 0 at enable) lasts `NOM + off(n)` clocks. Take k = floor(n/STEP) and m = k mod 4·DEV. Then off is m for m ≤ DEV, 2·DEV−m for m ≤ 3·DEV, and m−4·DEV otherwise. This gives a triangle that starts at 0 and rises first, with each level held for STEP periods.
- R4: Every switching period lies between NOM−DEV and NOM+DEV clocks inclusive.
- R5: The modulation sequence repeats exactly every 4·DEV·STEP switching periods.
- R6: `duty_win_o` is high from the first clock of each period for floor(3·P/4) clocks, where P is that period's length, and is low for the rest of the period.
- R7: From the clock after `run_i` is sampled low, `cyc_start_o` and `duty_win_o` are low and `ss_code_o` is 0. On re-enable, the modulation restarts at offset 0 and rising.
- R8: A `ss_start_i` pulse sampled with `run_i` high sets `ss_code_o` to 0. k clock edges later, `ss_code_o` equals min(255, floor(k/TICK)).
- R9: `ss_code_o` saturates at 255 and holds there until the next start pulse or until run is lost.
- R10: A `ss_start_i` pulse during a ramp restarts the ramp from 0.
- R11: A `ss_start_i` pulse sampled with `run_i` low is ignored. Without a start pulse, `ss_code_o` stays 0 while running.
- R12: Apart from restart and run loss, `ss_code_o` changes by at most +1 per clock and never decreases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Run enable |
| ss_start_i | input | 1 | Soft-start start pulse |
| cyc_start_o | output | 1 | One-clock pulse at the start of each switching period |
| duty_win_o | output | 1 | Maximum-duty window |
| ss_code_o | output | SS_W | Soft-start duty-limit code |

## Verification
The run enable passes through one register. As a result, the first cycle-start pulse appears one clock after `run_i` is sampled high, and the outputs go quiet one clock after it is sampled low. The ramp code reacts at the very edge that samples a start pulse, and it is checked k edges later against floor(k/TICK). Period lengths and window widths are measured by counting falling edges from one start pulse to the next. Each measurement is compared with the triangle formula for that period's index. All inputs change and all outputs are sampled on falling edges, so each check lands a known number of registers after its stimulus.

// File: rtl/osc_pkg.sv
package osc_pkg;
  typedef enum logic {DIR_UP = 1'b0, DIR_DN = 1'b1} tri_dir_e;
endpackage

// File: rtl/osc_tri.sv
module osc_tri
  import osc_pkg::*;
#(
  parameter int unsigned DEV      = 12,
  parameter int unsigned STEP_LEN = 5,
  parameter int unsigned OFF_W    = 5
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    run_i,
  input  logic                    adv_i,
  output logic signed [OFF_W-1:0] off_nxt_o
);
  localparam int unsigned SC_W = (STEP_LEN > 1) ? $clog2(STEP_LEN) : 1;
  localparam logic [SC_W-1:0] SC_LAST = SC_W'(STEP_LEN - 1);
  localparam logic signed [OFF_W-1:0] OFF_HI  = OFF_W'(DEV);
  localparam logic signed [OFF_W-1:0] OFF_LO  = -OFF_HI;
  localparam logic signed [OFF_W-1:0] OFF_ONE = OFF_W'(1);

  logic signed [OFF_W-1:0] off_q;
  logic [SC_W-1:0]         sc_q;
  tri_dir_e                dir_q, dir_nxt;
  logic                    step_now;

  assign step_now = adv_i && (sc_q == SC_LAST);

  always_comb begin
    off_nxt_o = off_q;
    dir_nxt   = dir_q;
    if (step_now) begin
      if (dir_q == DIR_UP) begin
        off_nxt_o = off_q + OFF_ONE;
        if (off_q + OFF_ONE == OFF_HI) dir_nxt = DIR_DN;
      end else begin
        off_nxt_o = off_q - OFF_ONE;
        if (off_q - OFF_ONE == OFF_LO) dir_nxt = DIR_UP;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      off_q <= '0;
      sc_q  <= '0;
      dir_q <= DIR_UP;
    end else if (!run_i) begin
      off_q <= '0;
      sc_q  <= '0;
      dir_q <= DIR_UP;
    end else if (adv_i) begin
      off_q <= off_nxt_o;
      dir_q <= dir_nxt;
      sc_q  <= step_now ? '0 : sc_q + 1'b1;
    end
  end
endmodule

// File: rtl/osc_period.sv
module osc_period #(
  parameter int unsigned PER_NOM = 307,
  parameter int unsigned PER_W   = 9,
  parameter int unsigned OFF_W   = 5
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    run_i,
  input  logic signed [OFF_W-1:0] off_nxt_i,
  output logic                    wrap_o,
  output logic                    start_o,
  output logic                    duty_o
);
  localparam logic [PER_W-1:0] NOM = PER_W'(PER_NOM);

  logic [PER_W-1:0] cnt_q, per_q, max_on;

  assign wrap_o  = run_i && (cnt_q == per_q - 1'b1);
  // three quarters of the live period, rounded down
  assign max_on  = PER_W'(({2'b00, per_q} + {1'b0, per_q, 1'b0}) >> 2);
  assign start_o = run_i && (cnt_q == '0);
  assign duty_o  = run_i && (cnt_q < max_on);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      per_q <= NOM;
    end else if (!run_i) begin
      cnt_q <= '0;
      per_q <= NOM;
    end else if (wrap_o) begin
      cnt_q <= '0;
      per_q <= PER_W'($signed({1'b0, NOM}) + (PER_W+1)'(off_nxt_i));
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/osc_softstart.sv
module osc_softstart #(
  parameter int unsigned SS_W    = 8,
  parameter int unsigned SS_TICK = 1568
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            run_i,
  input  logic            start_i,
  output logic [SS_W-1:0] code_o
);
  localparam int unsigned TICK_W = (SS_TICK > 1) ? $clog2(SS_TICK) : 1;
  localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(SS_TICK - 1);
  localparam logic [SS_W-1:0]   CODE_TOP  = '1;

  logic [TICK_W-1:0] tick_q;
  logic [SS_W-1:0]   code_q;
  logic              act_q;

  assign code_o = code_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tick_q <= '0;
      code_q <= '0;
      act_q  <= 1'b0;
    end else if (!run_i) begin
      tick_q <= '0;
      code_q <= '0;
      act_q  <= 1'b0;
    end else if (start_i) begin
      tick_q <= '0;
      code_q <= '0;
      act_q  <= 1'b1;
    end else if (act_q) begin
      if (tick_q == TICK_LAST) begin
        tick_q <= '0;
        code_q <= code_q + 1'b1;
        if (code_q == CODE_TOP - 1'b1) act_q <= 1'b0;
      end else begin
        tick_q <= tick_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/jitter_pwm_osc.sv
module jitter_pwm_osc #(
  parameter int unsigned SYS_CLK_KHZ = 20000,
  parameter int unsigned SW_KHZ      = 65,
  parameter int unsigned DEV_PCT     = 4,
  parameter int unsigned MOD_US      = 4000,
  parameter int unsigned SOFT_MS     = 20,
  parameter int unsigned SS_W        = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            run_i,
  input  logic            ss_start_i,
  output logic            cyc_start_o,
  output logic            duty_win_o,
  output logic [SS_W-1:0] ss_code_o
);
  localparam int unsigned PER_NOM   = SYS_CLK_KHZ / SW_KHZ;
  localparam int unsigned PER_DEV_R = PER_NOM * DEV_PCT / 100;
  localparam int unsigned PER_DEV   = (PER_DEV_R < 1) ? 1 : PER_DEV_R;
  localparam int unsigned SW_SWEEP  = SW_KHZ * MOD_US / 1000;
  localparam int unsigned QUARTER   = SW_SWEEP / 4;
  localparam int unsigned STEP_R    = QUARTER / PER_DEV;
  localparam int unsigned STEP_LEN  = (STEP_R < 1) ? 1 : STEP_R;
  localparam int unsigned PER_W     = $clog2(PER_NOM + PER_DEV + 1);
  localparam int unsigned OFF_W     = $clog2(PER_DEV + 1) + 1;
  localparam int unsigned SS_CLKS   = SYS_CLK_KHZ * SOFT_MS;
  localparam int unsigned SS_MAX    = (1 << SS_W) - 1;
  localparam int unsigned SS_TICK_R = SS_CLKS / SS_MAX;
  localparam int unsigned SS_TICK   = (SS_TICK_R < 1) ? 1 : SS_TICK_R;

  logic                    run_q;
  logic                    wrap;
  logic signed [OFF_W-1:0] off_nxt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= 1'b0;
    else         run_q <= run_i;
  end

  osc_tri #(.DEV(PER_DEV), .STEP_LEN(STEP_LEN), .OFF_W(OFF_W)) u_tri (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run_q),
    .adv_i     (wrap),
    .off_nxt_o (off_nxt)
  );

  osc_period #(.PER_NOM(PER_NOM), .PER_W(PER_W), .OFF_W(OFF_W)) u_per (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run_q),
    .off_nxt_i (off_nxt),
    .wrap_o    (wrap),
    .start_o   (cyc_start_o),
    .duty_o    (duty_win_o)
  );

  osc_softstart #(.SS_W(SS_W), .SS_TICK(SS_TICK)) u_ss (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (run_i),
    .start_i (ss_start_i),
    .code_o  (ss_code_o)
  );
endmodule

// File: rtl/osc_chk.sv
module osc_chk #(
  parameter int unsigned PER_MIN = 295,
  parameter int unsigned PER_MAX = 319,
  parameter int unsigned SS_W    = 8
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            run_i,
  input logic            ss_start_i,
  input logic            cyc_start_o,
  input logic            duty_win_o,
  input logic [SS_W-1:0] ss_code_o
);
  int unsigned gap_q, dcnt_q;
  logic        seen_q, run_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q  <= 0;
      dcnt_q <= 0;
      seen_q <= 1'b0;
      run_d  <= 1'b0;
    end else begin
      run_d  <= run_i;
      gap_q  <= cyc_start_o ? 1 : gap_q + 1;
      dcnt_q <= cyc_start_o ? (duty_win_o ? 1 : 0) : dcnt_q + (duty_win_o ? 1 : 0);
      if (!run_d)           seen_q <= 1'b0;
      else if (cyc_start_o) seen_q <= 1'b1;
    end
  end

  assert_start_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_start_o |=> !cyc_start_o);

  assert_period_bounds_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_start_o && seen_q) |-> (gap_q >= PER_MIN && gap_q <= PER_MAX));

  assert_window_opens_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_start_o |-> duty_win_o);

  assert_duty_ceiling_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_start_o && seen_q) |-> (dcnt_q * 4 <= gap_q * 3));

  assert_run_off_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (!cyc_start_o && !duty_win_o && ss_code_o == '0));

  assert_restart_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && ss_start_i) |=> ss_code_o == '0);

  assert_code_step_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !ss_start_i) |=> ({1'b0, ss_code_o} == {1'b0, $past(ss_code_o)} ||
                                {1'b0, ss_code_o} == {1'b0, $past(ss_code_o)} + 1'b1));
endmodule

bind jitter_pwm_osc osc_chk #(
  .PER_MIN (PER_NOM - PER_DEV),
  .PER_MAX (PER_NOM + PER_DEV),
  .SS_W    (SS_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .run_i       (run_i),
  .ss_start_i  (ss_start_i),
  .cyc_start_o (cyc_start_o),
  .duty_win_o  (duty_win_o),
  .ss_code_o   (ss_code_o)
);

// File: tb/jitter_pwm_osc_tb.sv
`timescale 1ns/1ps
module jitter_pwm_osc_tb;
  localparam int SYS   = 3250;
  localparam int SW    = 65;
  localparam int DEVP  = 4;
  localparam int SOFT  = 10;
  localparam int NOM   = SYS / SW;                 // 50
  localparam int DEV   = NOM * DEVP / 100;         // 2
  localparam int STEP  = (SW * 4000 / 1000 / 4) / DEV; // 32
  localparam int SWEEP = 4 * DEV * STEP;           // 256
  localparam int TICK  = SYS * SOFT / 255;         // 127

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       run_i = 1'b0;
  logic       ss_start_i = 1'b0;
  logic       cyc_start_o, duty_win_o;
  logic [7:0] ss_code_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  jitter_pwm_osc #(.SYS_CLK_KHZ(SYS), .SW_KHZ(SW), .DEV_PCT(DEVP),
                   .MOD_US(4000), .SOFT_MS(SOFT), .SS_W(8)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .run_i(run_i), .ss_start_i(ss_start_i),
    .cyc_start_o(cyc_start_o), .duty_win_o(duty_win_o), .ss_code_o(ss_code_o));

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  endtask

  function automatic int tri_off(int n);
    int m = (n / STEP) % (4 * DEV);
    if (m <= DEV) return m;
    else if (m <= 3 * DEV) return 2 * DEV - m;
    else return m - 4 * DEV;
  endfunction

  task automatic adv(int n);
    repeat (n) @(negedge clk);
  endtask

  // call at a falling edge where cyc_start_o is high; returns at the next one
  task automatic next_period(output int p, output int d);
    p = 0;
    d = 0;
    do begin
      if (duty_win_o) d++;
      p++;
      @(negedge clk);
    end while (!cyc_start_o && p < 4 * NOM);
  endtask

  task automatic ss_pulse();
    ss_start_i = 1'b1;
    @(negedge clk);
    ss_start_i = 1'b0;
  endtask

  task automatic t_reset();
    adv(3);
    rst_ni = 1'b1;
    adv(4);
    chk("R1 start", int'(cyc_start_o), 0);
    chk("R1 duty", int'(duty_win_o), 0);
    chk("R1 code", int'(ss_code_o), 0);
  endtask

  task automatic t_first_pulse();
    run_i = 1'b1;
    @(negedge clk);
    chk("R2 first start", int'(cyc_start_o), 1);
    chk("R6 window at start", int'(duty_win_o), 1);
  endtask

  task automatic t_sweep();
    int p, d;
    for (int n = 0; n < 2 * SWEEP; n++) begin
      next_period(p, d);
      chk(n < SWEEP ? "R3 period" : "R5 repeat period", p, NOM + tri_off(n));
      chk("R6 window width", d, (3 * p) / 4);
      chk("R4 bounds", int'(p >= NOM - DEV && p <= NOM + DEV), 1);
    end
  endtask

  task automatic t_run_off();
    int bad = 0;
    int p, d;
    run_i = 1'b0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (cyc_start_o || duty_win_o || ss_code_o != 0) bad++;
    end
    chk("R7 quiet while off", bad, 0);
    run_i = 1'b1;
    @(negedge clk);
    chk("R7 restart pulse", int'(cyc_start_o), 1);
    for (int n = 0; n < STEP + 2; n++) begin
      next_period(p, d);
      chk("R7 modulation restart", p, (n < STEP) ? NOM : NOM + 1);
    end
  endtask

  task automatic t_ramp();
    ss_pulse();
    chk("R8 k=0", int'(ss_code_o), 0);
    adv(TICK - 1);
    chk("R8 k=TICK-1", int'(ss_code_o), 0);
    adv(1);
    chk("R8 k=TICK", int'(ss_code_o), 1);
    adv(99 * TICK);
    chk("R8 k=100*TICK", int'(ss_code_o), 100);
    adv(155 * TICK - 1);
    chk("R8 k=255*TICK-1", int'(ss_code_o), 254);
    adv(1);
    chk("R9 full scale", int'(ss_code_o), 255);
    adv(1000);
    chk("R9 hold", int'(ss_code_o), 255);
  endtask

  task automatic t_restart();
    ss_pulse();
    chk("R10 restart from full", int'(ss_code_o), 0);
    adv(3 * TICK);
    chk("R10 ramp after restart", int'(ss_code_o), 3);
    ss_pulse();
    chk("R10 restart mid ramp", int'(ss_code_o), 0);
    adv(TICK);
    chk("R10 ramp resumes", int'(ss_code_o), 1);
  endtask

  task automatic t_idle();
    run_i = 1'b0;
    adv(2);
    chk("R7 code cleared", int'(ss_code_o), 0);
    ss_pulse();
    adv(2);
    run_i = 1'b1;
    adv(2 * TICK);
    chk("R11 pulse while off ignored", int'(ss_code_o), 0);
  endtask

  initial begin
    t_reset();
    t_first_pulse();
    t_sweep();
    t_run_off();
    t_ramp();
    t_restart();
    t_idle();
    summary();
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end
endmodule